// File: doc/BRIEF.md
# Processor Status Flag Unit

This unit keeps the program status flags of an 8-bit processor core and updates them each cycle. The ALU hands it an operation code, the two operand bytes and a single-bit input. From these it works out the carry and half-carry flags itself. Addition reports the carry out of the top bit. Subtraction reports the borrow. A rotate copies the bit that falls off the end into carry. The single-bit operations use carry as their one-bit accumulator. A two-bit register-bank field changes only when an explicit bank-select command carries a new bank number.

The unit also decides whether a maskable vectored interrupt request may be taken. A small state machine holds the global interrupt-enable flag and the in-service priority flag as one of four named states:

- `IS_OFF_NEST`: enable 0, priority 0.
- `IS_OFF_FULL`: enable 0, priority 1.
- `IS_HIGH_ONLY`: enable 1, priority 0.
- `IS_ALL`: enable 1, priority 1.

The transitions are:

- `IS_ALL` goes to `IS_OFF_FULL` when it accepts a low-class request.
- `IS_ALL` goes to `IS_OFF_NEST` when it accepts a high-class request.
- `IS_HIGH_ONLY` goes to `IS_OFF_NEST` when it accepts a high-class request.
- A restore jumps from any state to the state given by the enable and priority bits of the restored byte.
- In every other case the state machine stays where it is.

The restore input loads the whole status byte in one cycle, for a return from interrupt.

Top module: `status_flag_unit`

## Requirements
- R1: A synchronous reset (rst=1 at a clock edge) makes psw read 8'h02: in-service priority 1, all other flags 0, bank 0. The status byte layout is bit0 carry, bit1 in-service priority, bits3:2 bank, bit4 half-carry, bits6:5 always 0, bit7 interrupt enable.
- R2: With op_sel=1 (add), carry becomes the carry out of opnd_a+opnd_b at bit 7, and half-carry becomes the carry out of bit 3 of the sum.
- R3: With op_sel=2 (subtract opnd_b from opnd_a), carry becomes 1 exactly when opnd_a<opnd_b unsigned. Half-carry becomes 1 exactly when opnd_a[3:0]<opnd_b[3:0], which is a borrow into bit 3.
- R4: With op_sel=3 (rotate left), carry takes opnd_a[7]. With op_sel=4 (rotate right), carry takes opnd_a[0]. Half-carry does not change in either case.
- R5: With op_sel=5, carry becomes carry AND bit_in. With op_sel=6, carry becomes carry OR bit_in. With op_sel=7, carry becomes bit_in. Half-carry does not change for any of the three.
- R6: The bank field takes bank_num only in a cycle with bank_wr=1. In every other cycle it keeps its value.
- R7: irq_ack is asserted in the same cycle as a high-class request (irq_req=1, irq_low=0) exactly when the interrupt-enable flag is 1.
- R8: A low-class request (irq_low=1) is acknowledged only when both the interrupt-enable flag and the in-service priority flag are 1.
- R9: After an acknowledge, interrupt enable reads 0. After a high-class acknowledge, in-service priority also reads 0. After a low-class acknowledge, in-service priority keeps its value.
- R10: When restore_en=1, psw takes restore_byte with bits 6:5 forced to 0. This overrides any operation, bank write or acknowledge in that same cycle.
- R11: With op_sel=0, carry and half-carry keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_sel | input | 3 | Operation code: 0 none, 1 add, 2 sub, 3 rotl, 4 rotr, 5 bit AND, 6 bit OR, 7 bit load |
| opnd_a | input | 8 | First ALU operand |
| opnd_b | input | 8 | Second ALU operand |
| bit_in | input | 1 | Single-bit operand for bit operations |
| bank_wr | input | 1 | Bank-select command |
| bank_num | input | 2 | Bank number carried by the command |
| restore_en | input | 1 | Load the whole status byte |
| restore_byte | input | 8 | Status byte to load |
| irq_req | input | 1 | Maskable vectored request pending |
| irq_low | input | 1 | Request class: 0 high, 1 low |
| irq_ack | output | 1 | Request accepted this cycle |
| psw | output | 8 | Current status byte |

## Verification
The bench aims at the nibble boundaries:

- 0x0F+0x01 and 0x10-0x01 set half-carry only. A design that takes the half-carry from the wrong bit would show it on carry or not at all.
- 0xFF+0x01 and 0x00-0x01 set both flags.

For the interrupt path, the bench sends a low-class request while in `IS_HIGH_ONLY` and a high-class request while in `IS_OFF_FULL`. A design that ignores the priority flag, or lets priority override the global enable, would acknowledge there.

The bench checks that the flag a rotate or bit operation must leave alone really stays put. It also checks that a restore issued together with an acknowledge still wins; a design with the wrong precedence would leave the enable cleared after the restore.

// File: rtl/sfu_pkg.sv
package sfu_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_ADD   = 3'd1,
        OP_SUB   = 3'd2,
        OP_ROTL  = 3'd3,
        OP_ROTR  = 3'd4,
        OP_BAND  = 3'd5,
        OP_BOR   = 3'd6,
        OP_BLOAD = 3'd7
    } alu_op_e;

    // encoding is {interrupt enable, in-service priority}
    typedef enum logic [1:0] {
        IS_OFF_NEST  = 2'b00,
        IS_OFF_FULL  = 2'b01,
        IS_HIGH_ONLY = 2'b10,
        IS_ALL       = 2'b11
    } irq_state_e;

    localparam int BANK_W   = 2;
    localparam int POS_CY   = 0;
    localparam int POS_ISP  = 1;
    localparam int POS_BANK = 2;
    localparam int POS_AC   = 4;
    localparam int POS_IE   = 7;

endpackage

// File: rtl/sfu_carry_logic.sv
module sfu_carry_logic
    import sfu_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int AUX_BIT = 3
) (
    input  alu_op_e             op,
    input  logic [DATA_W-1:0]   a,
    input  logic [DATA_W-1:0]   b,
    input  logic                bit_in,
    input  logic                cy_q,
    input  logic                ac_q,
    output logic                cy_d,
    output logic                ac_d
);

    localparam int LO_W = AUX_BIT + 1;

    logic              cy_add;
    logic              ac_add;
    logic [DATA_W-1:0] add_unused;
    logic [LO_W-1:0]   lo_unused;

    assign {cy_add, add_unused} = {1'b0, a} + {1'b0, b};
    assign {ac_add, lo_unused}  = {1'b0, a[LO_W-1:0]} + {1'b0, b[LO_W-1:0]};

    always_comb begin
        cy_d = cy_q;
        ac_d = ac_q;
        unique case (op)
            OP_NONE:  ;
            OP_ADD: begin
                cy_d = cy_add;
                ac_d = ac_add;
            end
            OP_SUB: begin
                cy_d = (a < b);
                ac_d = (a[LO_W-1:0] < b[LO_W-1:0]);
            end
            OP_ROTL:  cy_d = a[DATA_W-1];
            OP_ROTR:  cy_d = a[0];
            OP_BAND:  cy_d = cy_q & bit_in;
            OP_BOR:   cy_d = cy_q | bit_in;
            OP_BLOAD: cy_d = bit_in;
        endcase
    end

endmodule

// File: rtl/sfu_int_fsm.sv
module sfu_int_fsm
    import sfu_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic restore,
    input  logic restore_ie,
    input  logic restore_isp,
    input  logic irq_req,
    input  logic irq_low,
    output logic ack,
    output logic ie,
    output logic isp
);

    irq_state_e st_q;
    irq_state_e st_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= IS_OFF_FULL;
        else     st_q <= st_d;
    end

    // acceptance and next state
    always_comb begin
        ack  = 1'b0;
        st_d = st_q;
        unique case (st_q)
            IS_ALL: begin
                ack = irq_req;
                if (irq_req) st_d = irq_low ? IS_OFF_FULL : IS_OFF_NEST;
            end
            IS_HIGH_ONLY: begin
                ack = irq_req & ~irq_low;
                if (irq_req && !irq_low) st_d = IS_OFF_NEST;
            end
            IS_OFF_FULL, IS_OFF_NEST: ;
        endcase
        if (restore) st_d = irq_state_e'({restore_ie, restore_isp});
    end

    // flag outputs
    always_comb begin
        ie  = 1'b0;
        isp = 1'b0;
        unique case (st_q)
            IS_OFF_NEST:  begin ie = 1'b0; isp = 1'b0; end
            IS_OFF_FULL:  begin ie = 1'b0; isp = 1'b1; end
            IS_HIGH_ONLY: begin ie = 1'b1; isp = 1'b0; end
            IS_ALL:       begin ie = 1'b1; isp = 1'b1; end
        endcase
    end

endmodule

// File: rtl/sfu_bank_reg.sv
module sfu_bank_reg #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restore,
    input  logic [W-1:0] restore_val,
    input  logic         wr,
    input  logic [W-1:0] val,
    output logic [W-1:0] bank
);

    always_ff @(posedge clk) begin
        if (rst)          bank <= '0;
        else if (restore) bank <= restore_val;
        else if (wr)      bank <= val;
    end

endmodule

// File: rtl/status_flag_unit.sv
module status_flag_unit
    import sfu_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int AUX_BIT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        op_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              bit_in,
    input  logic              bank_wr,
    input  logic [1:0]        bank_num,
    input  logic              restore_en,
    input  logic [7:0]        restore_byte,
    input  logic              irq_req,
    input  logic              irq_low,
    output logic              irq_ack,
    output logic [7:0]        psw
);

    logic              cy_q, ac_q, cy_d, ac_d;
    logic              ie, isp;
    logic [BANK_W-1:0] bank;
    logic              unused_rsv;

    assign unused_rsv = ^restore_byte[6:5];

    sfu_carry_logic #(.DATA_W(DATA_W), .AUX_BIT(AUX_BIT)) u_carry (
        .op     (alu_op_e'(op_sel)),
        .a      (opnd_a),
        .b      (opnd_b),
        .bit_in (bit_in),
        .cy_q   (cy_q),
        .ac_q   (ac_q),
        .cy_d   (cy_d),
        .ac_d   (ac_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cy_q <= 1'b0;
            ac_q <= 1'b0;
        end else if (restore_en) begin
            cy_q <= restore_byte[POS_CY];
            ac_q <= restore_byte[POS_AC];
        end else begin
            cy_q <= cy_d;
            ac_q <= ac_d;
        end
    end

    sfu_int_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .restore     (restore_en),
        .restore_ie  (restore_byte[POS_IE]),
        .restore_isp (restore_byte[POS_ISP]),
        .irq_req     (irq_req),
        .irq_low     (irq_low),
        .ack         (irq_ack),
        .ie          (ie),
        .isp         (isp)
    );

    sfu_bank_reg #(.W(BANK_W)) u_bank (
        .clk         (clk),
        .rst         (rst),
        .restore     (restore_en),
        .restore_val (restore_byte[POS_BANK +: BANK_W]),
        .wr          (bank_wr),
        .val         (bank_num),
        .bank        (bank)
    );

    always_comb begin
        psw                        = '0;
        psw[POS_CY]                = cy_q;
        psw[POS_ISP]               = isp;
        psw[POS_BANK +: BANK_W]    = bank;
        psw[POS_AC]                = ac_q;
        psw[POS_IE]                = ie;
    end

endmodule

// File: rtl/status_flag_unit_chk.sv
module status_flag_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] op_sel,
    input logic       bank_wr,
    input logic       restore_en,
    input logic [7:0] restore_byte,
    input logic       irq_req,
    input logic       irq_low,
    input logic       irq_ack,
    input logic [7:0] psw
);

    p_reset_value_r1: assert property (@(posedge clk) rst |=> psw == 8'h02);

    p_ack_needs_ie_r7: assert property (@(posedge clk) disable iff (rst)
        irq_ack |-> (psw[7] && irq_req));

    p_low_needs_isp_r8: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && irq_low) |-> psw[1]);

    p_ack_clears_ie_r9: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !restore_en) |=> !psw[7]);

    p_high_ack_clears_isp_r9: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !irq_low && !restore_en) |=> !psw[1]);

    p_bank_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!bank_wr && !restore_en) |=> $stable(psw[3:2]));

    p_restore_load_r10: assert property (@(posedge clk) disable iff (rst)
        restore_en |=> psw == ($past(restore_byte) & 8'h9F));

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 3'd0 && !restore_en) |=> ($stable(psw[0]) && $stable(psw[4])));

    p_ac_hold_r4_r5: assert property (@(posedge clk) disable iff (rst)
        (op_sel >= 3'd3 && !restore_en) |=> $stable(psw[4]));

endmodule

bind status_flag_unit status_flag_unit_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .op_sel       (op_sel),
    .bank_wr      (bank_wr),
    .restore_en   (restore_en),
    .restore_byte (restore_byte),
    .irq_req      (irq_req),
    .irq_low      (irq_low),
    .irq_ack      (irq_ack),
    .psw          (psw)
);

// File: tb/status_flag_unit_test.sv
`timescale 1ns/1ps
module status_flag_unit_test;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] op_sel;
    logic [7:0] opnd_a, opnd_b;
    logic       bit_in, bank_wr, restore_en, irq_req, irq_low;
    logic [1:0] bank_num;
    logic [7:0] restore_byte;
    logic       irq_ack;
    logic [7:0] psw;

    always #5 clk = ~clk;

    status_flag_unit uut (
        .clk(clk), .rst(rst), .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .bit_in(bit_in), .bank_wr(bank_wr), .bank_num(bank_num),
        .restore_en(restore_en), .restore_byte(restore_byte),
        .irq_req(irq_req), .irq_low(irq_low), .irq_ack(irq_ack), .psw(psw)
    );

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t q[$];
    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;

    // reference model state
    logic m_cy, m_ac, m_ie, m_isp;
    logic [1:0] m_bank;

    function automatic logic [7:0] model_psw();
        return {m_ie, 2'b00, m_ac, m_bank, m_isp, m_cy};
    endfunction

    task automatic step(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b,
                        input logic bi, input logic bw, input logic [1:0] bn,
                        input logic rs, input logic [7:0] rb,
                        input logic rq, input logic lo, input string tag);
        logic       e_ack;
        logic [4:0] lo_sum;
        logic [8:0] sum;
        item_t      it;
        @(negedge clk);
        op_sel = op; opnd_a = a; opnd_b = b; bit_in = bi;
        bank_wr = bw; bank_num = bn; restore_en = rs; restore_byte = rb;
        irq_req = rq; irq_low = lo;
        #1;
        e_ack = rq & m_ie & (~lo | m_isp);
        n_chk++;
        if (irq_ack !== e_ack) begin
            n_fail++;
            $display("FAIL %s ack: actual %b expected %b", tag, irq_ack, e_ack);
        end
        sum    = {1'b0, a} + {1'b0, b};
        lo_sum = {1'b0, a[3:0]} + {1'b0, b[3:0]};
        case (op)
            3'd1: begin m_cy = sum[8]; m_ac = lo_sum[4]; end
            3'd2: begin m_cy = (a < b); m_ac = (a[3:0] < b[3:0]); end
            3'd3: m_cy = a[7];
            3'd4: m_cy = a[0];
            3'd5: m_cy = m_cy & bi;
            3'd6: m_cy = m_cy | bi;
            3'd7: m_cy = bi;
            default: ;
        endcase
        if (bw) m_bank = bn;
        if (e_ack) begin
            m_ie = 1'b0;
            if (!lo) m_isp = 1'b0;
        end
        if (rs) begin
            m_cy = rb[0]; m_isp = rb[1]; m_bank = rb[3:2]; m_ac = rb[4]; m_ie = rb[7];
        end
        @(posedge clk);
        #1;
        it.exp = model_psw();
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic idle_op(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b,
                           input logic bi, input string tag);
        step(op, a, b, bi, 1'b0, 2'd0, 1'b0, 8'h00, 1'b0, 1'b0, tag);
    endtask

    task automatic irq(input logic lo, input string tag);
        step(3'd0, 8'h00, 8'h00, 1'b0, 1'b0, 2'd0, 1'b0, 8'h00, 1'b1, lo, tag);
    endtask

    task automatic restore(input logic [7:0] rb, input string tag);
        step(3'd0, 8'h00, 8'h00, 1'b0, 1'b0, 2'd0, 1'b1, rb, 1'b0, 1'b0, tag);
    endtask

    // monitor: compares the status byte one cycle after each driven item
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            n_chk++;
            if (psw !== it.exp) begin
                n_fail++;
                $display("FAIL %s psw: actual %h expected %h", it.tag, psw, it.exp);
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; op_sel = 0; opnd_a = 0; opnd_b = 0; bit_in = 0; bank_wr = 0;
        bank_num = 0; restore_en = 0; restore_byte = 0; irq_req = 0; irq_low = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_cy = 0; m_ac = 0; m_ie = 0; m_isp = 1; m_bank = 0;
        n_chk++;
        if (psw !== 8'h02) begin
            n_fail++;
            $display("FAIL R1 reset: actual %h expected %h", psw, 8'h02);
        end

        // R2 add
        idle_op(3'd1, 8'h0F, 8'h01, 0, "R2 0F+01");
        idle_op(3'd1, 8'hF0, 8'h10, 0, "R2 F0+10");
        idle_op(3'd1, 8'hFF, 8'h01, 0, "R2 FF+01");
        idle_op(3'd1, 8'h12, 8'h34, 0, "R2 12+34");
        // R3 subtract
        idle_op(3'd2, 8'h10, 8'h01, 0, "R3 10-01");
        idle_op(3'd2, 8'h05, 8'h10, 0, "R3 05-10");
        idle_op(3'd2, 8'h00, 8'h01, 0, "R3 00-01");
        idle_op(3'd2, 8'h55, 8'h11, 0, "R3 55-11");
        // R4 rotate, half-carry set first to catch a spurious clear
        idle_op(3'd1, 8'h08, 8'h08, 0, "R2 set ac");
        idle_op(3'd3, 8'h80, 8'h00, 0, "R4 rotl 80");
        idle_op(3'd4, 8'h02, 8'h00, 0, "R4 rotr 02");
        idle_op(3'd4, 8'h01, 8'h00, 0, "R4 rotr 01");
        // R5 bit operations
        idle_op(3'd5, 8'h00, 8'h00, 1, "R5 and 1");
        idle_op(3'd5, 8'h00, 8'h00, 0, "R5 and 0");
        idle_op(3'd6, 8'h00, 8'h00, 1, "R5 or 1");
        idle_op(3'd7, 8'h00, 8'h00, 0, "R5 load 0");
        idle_op(3'd7, 8'h00, 8'h00, 1, "R5 load 1");
        // R11 no operation leaves flags
        idle_op(3'd0, 8'hFF, 8'hFF, 0, "R11 none");
        // R6 bank select
        step(3'd0, 0, 0, 0, 1, 2'd3, 0, 8'h00, 0, 0, "R6 bank 3");
        step(3'd1, 8'h01, 8'h01, 0, 0, 2'd1, 0, 8'h00, 0, 0, "R6 no write");
        step(3'd0, 0, 0, 0, 1, 2'd1, 0, 8'h00, 0, 0, "R6 bank 1");
        // R7 with enable off: high request refused
        irq(1'b0, "R7 ie off");
        // R10 full restore, reserved bits dropped
        restore(8'hFF, "R10 restore FF");
        // R8/R9 low request accepted in IS_ALL, isp kept
        irq(1'b1, "R8 low ok");
        irq(1'b1, "R9 low after ack");
        // enable only, priority 0
        restore(8'h80, "R10 restore 80");
        irq(1'b1, "R8 low blocked");
        irq(1'b0, "R7 high ok");
        irq(1'b0, "R9 high after ack");
        // R10 restore wins over a simultaneous acknowledge
        restore(8'h82, "R10 restore 82");
        step(3'd1, 8'hFF, 8'h01, 0, 1, 2'd2, 1, 8'h93, 1, 0, "R10 restore vs ack");
        irq(1'b0, "R7 high after restore");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule